// File: doc/BRIEF.md
# Quadword Load/Store Sequencer

This block takes one 128-bit memory request and turns it into two 64-bit transactions on a single request/acknowledge memory port. The effective address is the base register value plus a sign-extended 16-bit displacement. The four lowest address bits are then forced to zero, so every quadword access falls on a 16-byte boundary.

The lower doubleword always travels first, at the aligned address. The upper doubleword follows at the aligned address plus 8. A store always drives both beats to memory. A load collects both returned doublewords and then presents the whole 128-bit value with a one-cycle write strobe, addressed to the destination register index. A load aimed at register index zero has no effect at all.

While a request is in flight the block reports itself busy, and any new request offered in that time is dropped. The pipeline above it holds its request until busy is low.

Top module: `qword_lsq`

## Requirements
- R1: The access address is `req_base + sign_extend(req_offset)` (16-bit offset, two's complement) with bits [3:0] cleared; no beat address has any of bits [3:0] set other than bit 3 of the second beat.
- R2: The first beat uses the aligned address. For a store it carries `req_wdata[63:0]`. For a load its returned data becomes bits [63:0] of the result.
- R3: The second beat uses the aligned address plus 8. For a store it carries `req_wdata[127:64]`. For a load its returned data becomes bits [127:64] of the result.
- R4: A load (`req_store`=0) with `req_dst`=0 is accepted as a no-op: it issues no memory request, does not raise `busy` and produces no `ld_we`.
- R5: A store is always performed, including when `req_dst`=0; both beats are issued with `mem_we`=1.
- R6: Address, write flag and write data of a beat are held stable while `mem_req` is high and `mem_ack` is low. The second beat is issued only after the first beat's acknowledge. Exactly two beats are issued per accepted request.
- R7: `busy` is high from the cycle after a request is accepted until the cycle after the second acknowledge. Requests presented while `busy` is high are ignored.
- R8: For a load, `ld_we` pulses high for exactly one cycle, in the cycle after the second acknowledge, with the assembled `ld_data` and the request's index on `ld_dst`. A store never raises `ld_we`.
- R9: After reset, `mem_req`, `busy` and `ld_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | AW (32) | Base register value |
| req_offset | input | OFF_W (16) | Signed displacement |
| req_wdata | input | 128 | Store data |
| req_dst | input | IW (5) | Destination/source register index |
| busy | output | 1 | Request in flight; new requests ignored |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW (32) | Beat byte address |
| mem_wdata | output | 64 | Beat write data |
| mem_ack | input | 1 | Beat accepted / read data valid |
| mem_rdata | input | 64 | Beat read data |
| ld_we | output | 1 | Load result write strobe |
| ld_dst | output | IW (5) | Load result register index |
| ld_data | output | 128 | Assembled load result |

## Verification
The hardest situation to reach from the ports is a second request that arrives while a request is still in flight. It must be dropped, even when the offer is held up to the very edge at which the sequencer returns to idle. The bench reaches this by holding a conflicting store on the request inputs for every cycle in which `busy` reads high. It then checks that only the original two read beats reached memory and that no further beat followed. Beat stability is exercised by a memory model with a variable acknowledge latency that compares each waiting beat against its first-seen address. Negative and maximum displacements are also covered, including one that wraps the address below zero.

// File: rtl/qls_pkg.sv
package qls_pkg;
   localparam int BEAT_W = 64;
   localparam int QW_W   = 2 * BEAT_W;

   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_LO   = 2'd1,
      QS_HI   = 2'd2
   } qs_state_t;
endpackage

// File: rtl/qls_addr_gen.sv
module qls_addr_gen #(
   parameter int AW    = 32,
   parameter int OFF_W = 16
) (
   input  logic [AW-1:0]    base,
   input  logic [OFF_W-1:0] offset,
   output logic [AW-5:0]    quad_idx
);
   logic [AW-1:0] off_ext;
   logic [AW-1:0] eff;

   generate
      if (AW < OFF_W || AW < 5) begin : g_bad_width
         $error("qls_addr_gen: AW must be >= OFF_W and >= 5");
      end
      if (AW > OFF_W) begin : g_sext
         assign off_ext = {{(AW-OFF_W){offset[OFF_W-1]}}, offset};
      end else begin : g_same
         assign off_ext = offset;
      end
   endgenerate

   assign eff      = base + off_ext;
   // R1: dropping bits [3:0] yields the 16-byte aligned quadword index
   assign quad_idx = eff[AW-1:4];
endmodule

// File: rtl/qls_seq.sv
module qls_seq
   import qls_pkg::*;
#(
   parameter int AW = 32,
   parameter int IW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [IW-1:0]     req_dst,
   input  logic [AW-5:0]     quad_idx,
   input  logic [QW_W-1:0]   req_wdata,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [BEAT_W-1:0] mem_wdata,
   input  logic              mem_ack,
   output logic              take_lo,
   output logic              finish_ld,
   output logic [IW-1:0]     dst_q
);
   qs_state_t           state;
   logic [AW-5:0]       idx_q;
   logic [QW_W-1:0]     wd_q;
   logic                st_q;
   logic                accept;
   logic                hi_beat;

   // R4: a load to index zero is not accepted into the sequencer
   assign accept  = req_valid && (state == QS_IDLE) && (req_store || (req_dst != '0));
   assign hi_beat = (state == QS_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= QS_IDLE;
         idx_q <= '0;
         wd_q  <= '0;
         st_q  <= 1'b0;
         dst_q <= '0;
      end else begin
         case (state)
            QS_IDLE: if (accept) begin
               state <= QS_LO;
               idx_q <= quad_idx;
               wd_q  <= req_wdata;
               st_q  <= req_store;
               dst_q <= req_dst;
            end
            QS_LO:   if (mem_ack) state <= QS_HI;
            QS_HI:   if (mem_ack) state <= QS_IDLE;
            default: state <= QS_IDLE;
         endcase
      end
   end

   assign busy      = (state != QS_IDLE);
   assign mem_req   = busy;
   assign mem_we    = st_q;
   assign mem_addr  = {idx_q, hi_beat, 3'b000};
   assign mem_wdata = hi_beat ? wd_q[QW_W-1:BEAT_W] : wd_q[BEAT_W-1:0];
   assign take_lo   = (state == QS_LO) && mem_ack;
   assign finish_ld = hi_beat && mem_ack && !st_q;

   a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r3_second_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_addr[3] |=> mem_req && (mem_addr == $past(mem_addr) + AW'(8)));

   a_r7_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_addr[3] |=> !busy);

   a_r4_zero_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && req_valid && !req_store && (req_dst == '0) |=> !mem_req);

   a_r5_store_issues: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && req_valid && req_store |=> mem_req && mem_we && !mem_addr[3]);

   a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[2:0] == 3'b000));
endmodule

// File: rtl/qls_gather.sv
module qls_gather
   import qls_pkg::*;
#(
   parameter int IW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_lo,
   input  logic              finish_ld,
   input  logic [BEAT_W-1:0] rdata,
   input  logic [IW-1:0]     dst_in,
   output logic              ld_we,
   output logic [IW-1:0]     ld_dst,
   output logic [QW_W-1:0]   ld_data
);
   logic [BEAT_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q    <= '0;
         ld_we   <= 1'b0;
         ld_dst  <= '0;
         ld_data <= '0;
      end else begin
         ld_we <= finish_ld;
         if (take_lo) lo_q <= rdata;
         if (finish_ld) begin
            ld_data <= {rdata, lo_q};
            ld_dst  <= dst_in;
         end
      end
   end

   a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we |=> !ld_we);

   a_r8_after_upper: assert property (@(posedge clk) disable iff (!rst_n)
      finish_ld |=> ld_we && (ld_data[QW_W-1:BEAT_W] == $past(rdata)));
endmodule

// File: rtl/qword_lsq.sv
module qword_lsq
   import qls_pkg::*;
#(
   parameter int AW    = 32,
   parameter int OFF_W = 16,
   parameter int IW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [AW-1:0]     req_base,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [QW_W-1:0]   req_wdata,
   input  logic [IW-1:0]     req_dst,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [BEAT_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [BEAT_W-1:0] mem_rdata,
   output logic              ld_we,
   output logic [IW-1:0]     ld_dst,
   output logic [QW_W-1:0]   ld_data
);
   logic [AW-5:0] quad_idx;
   logic          take_lo;
   logic          finish_ld;
   logic [IW-1:0] dst_q;

   generate
      if (IW < 1) begin : g_bad_iw
         $error("qword_lsq: IW must be at least 1");
      end
   endgenerate

   qls_addr_gen #(.AW(AW), .OFF_W(OFF_W)) u_addr (
      .base     (req_base),
      .offset   (req_offset),
      .quad_idx (quad_idx)
   );

   qls_seq #(.AW(AW), .IW(IW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_store (req_store),
      .req_dst   (req_dst),
      .quad_idx  (quad_idx),
      .req_wdata (req_wdata),
      .busy      (busy),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .take_lo   (take_lo),
      .finish_ld (finish_ld),
      .dst_q     (dst_q)
   );

   qls_gather #(.IW(IW)) u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_lo   (take_lo),
      .finish_ld (finish_ld),
      .rdata     (mem_rdata),
      .dst_in    (dst_q),
      .ld_we     (ld_we),
      .ld_dst    (ld_dst),
      .ld_data   (ld_data)
   );

   a_r9_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !mem_req && !busy && !ld_we);

   a_r8_no_store_result: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |=> !ld_we);
endmodule

// File: tb/sim_qword_lsq.sv
module sim_qword_lsq;
   localparam int AW = 32;
   localparam int OFF_W = 16;
   localparam int IW = 5;
   localparam int NV = 8;

   // vector: {store, dst[4:0], offset[15:0], base[31:0]}
   localparam logic [53:0] VEC [NV] = '{
      {1'b0, 5'd3,  16'h0000, 32'h0000_0100},
      {1'b0, 5'd7,  16'h000B, 32'h0000_0105},
      {1'b1, 5'd2,  16'hFFF8, 32'h0000_0140},
      {1'b0, 5'd9,  16'h0000, 32'h0000_0130},
      {1'b1, 5'd0,  16'h000F, 32'h0000_01F0},
      {1'b0, 5'd31, 16'hFFFF, 32'h0000_01F3},
      {1'b0, 5'd1,  16'h8000, 32'h0000_0000},
      {1'b1, 5'd4,  16'h7FFF, 32'h1234_5678}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_store = 1'b0;
   logic [AW-1:0] req_base = '0;
   logic [OFF_W-1:0] req_offset = '0;
   logic [127:0] req_wdata = '0;
   logic [IW-1:0] req_dst = '0;
   logic busy, mem_req, mem_we, ld_we;
   logic [AW-1:0] mem_addr;
   logic [63:0] mem_wdata;
   logic mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic [IW-1:0] ld_dst;
   logic [127:0] ld_data;

   always #5 clk = ~clk;

   qword_lsq #(.AW(AW), .OFF_W(OFF_W), .IW(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
      .req_dst(req_dst), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .ld_we(ld_we), .ld_dst(ld_dst), .ld_data(ld_data)
   );

   int checks = 0;
   int errors = 0;

   // bench memory model
   logic [63:0] mem [64];
   int lat = 0;
   int wcnt = 0;
   bit pend = 0;
   logic [AW-1:0] pend_addr;
   int stab_err = 0;
   int beat_n = 0;
   logic [AW-1:0] beat_addr [4];
   logic beat_we [4];
   logic [63:0] beat_wd [4];
   int ld_cnt = 0;
   logic [127:0] ld_cap;
   logic [IW-1:0] ld_dst_cap;

   always @(negedge clk) begin
      if (ld_we) begin
         ld_cnt++;
         ld_cap = ld_data;
         ld_dst_cap = ld_dst;
      end
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (!pend) begin
            pend = 1;
            pend_addr = mem_addr;
            wcnt = 0;
         end else if (mem_addr != pend_addr) begin
            stab_err++;
         end
         if (wcnt >= lat) begin
            mem_ack = 1'b1;
            mem_rdata = mem[mem_addr[8:3]];
            if (mem_we) mem[mem_addr[8:3]] = mem_wdata;
            if (beat_n < 4) begin
               beat_addr[beat_n] = mem_addr;
               beat_we[beat_n] = mem_we;
               beat_wd[beat_n] = mem_wdata;
            end
            beat_n++;
            pend = 0;
         end else begin
            wcnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] aligned_of(input logic [AW-1:0] b, input logic [OFF_W-1:0] o);
      logic [AW-1:0] e;
      e = b + {{(AW-OFF_W){o[OFF_W-1]}}, o};
      return {e[AW-1:4], 4'h0};
   endfunction

   task automatic run_req(input bit st, input logic [IW-1:0] d, input logic [OFF_W-1:0] o,
                          input logic [AW-1:0] b, input logic [127:0] wd, input int l);
      logic [AW-1:0] al;
      logic [63:0] exp_lo, exp_hi;
      al = aligned_of(b, o);
      exp_lo = mem[al[8:3]];
      exp_hi = mem[(al + 8) >> 3 & 63];
      lat = l;
      beat_n = 0;
      ld_cnt = 0;
      stab_err = 0;
      req_valid = 1; req_store = st; req_dst = d; req_offset = o; req_base = b; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      chk(busy === 1'b1, "R7 busy after accept", 128'(busy), 128'd1);
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(beat_n == 2, "R6 two beats", 128'(beat_n), 128'd2);
      chk(stab_err == 0, "R6 beat held stable", 128'(stab_err), 128'd0);
      chk(beat_addr[0] == al, "R1 R2 first beat address", 128'(beat_addr[0]), 128'(al));
      chk(beat_addr[1] == al + 8, "R3 second beat address", 128'(beat_addr[1]), 128'(al + 8));
      if (st) begin
         chk(beat_we[0] && beat_we[1], "R5 store writes", 128'({beat_we[0], beat_we[1]}), 128'd3);
         chk(beat_wd[0] == wd[63:0], "R2 store low data", 128'(beat_wd[0]), 128'(wd[63:0]));
         chk(beat_wd[1] == wd[127:64], "R3 store high data", 128'(beat_wd[1]), 128'(wd[127:64]));
         chk(ld_cnt == 0, "R8 no result for store", 128'(ld_cnt), 128'd0);
      end else begin
         chk(ld_cnt == 1, "R8 single result strobe", 128'(ld_cnt), 128'd1);
         chk(ld_cap == {exp_hi, exp_lo}, "R2 R3 load assembly", ld_cap, {exp_hi, exp_lo});
         chk(ld_dst_cap == d, "R8 result index", 128'(ld_dst_cap), 128'(d));
      end
   endtask

   initial begin
      #500000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = {32'hA5A5_0000 + 32'(i), 32'h5A5A_0000 + 32'(i * 3)};
      repeat (3) @(negedge clk);
      chk(!mem_req && !busy && !ld_we, "R9 reset state", 128'({mem_req, busy, ld_we}), 128'd0);
      rst_n = 1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [127:0] wd;
         wd = {32'hC0DE_0000 + 32'(v), 32'h1111_0000 + 32'(v), 32'h2222_0000 + 32'(v), 32'h3333_0000 + 32'(v)};
         run_req(VEC[v][53], VEC[v][52:48], VEC[v][47:32], VEC[v][31:0], wd, v % 3);
      end

      // R4: load to index zero does nothing
      beat_n = 0; ld_cnt = 0;
      req_valid = 1; req_store = 0; req_dst = '0; req_base = 32'h100; req_offset = '0;
      @(negedge clk);
      req_valid = 0;
      chk(busy === 1'b0, "R4 zero-index load no busy", 128'(busy), 128'd0);
      repeat (4) @(negedge clk);
      chk(beat_n == 0, "R4 zero-index load no beat", 128'(beat_n), 128'd0);
      chk(ld_cnt == 0, "R4 zero-index load no result", 128'(ld_cnt), 128'd0);

      // R7: offers held during busy are dropped
      beat_n = 0; ld_cnt = 0; lat = 2;
      req_valid = 1; req_store = 0; req_dst = 5'd6; req_base = 32'h150; req_offset = '0;
      @(negedge clk);
      req_store = 1; req_dst = 5'd8; req_base = 32'h180; req_wdata = {4{32'hDEAD_BEEF}};
      while (busy) @(negedge clk);
      req_valid = 0;
      repeat (5) @(negedge clk);
      chk(beat_n == 2, "R7 only original beats", 128'(beat_n), 128'd2);
      chk(!beat_we[0] && !beat_we[1], "R7 no write from dropped offer", 128'({beat_we[0], beat_we[1]}), 128'd0);
      chk(mem[6'h30] != 64'hDEAD_BEEF_DEAD_BEEF, "R7 target untouched", 128'(mem[6'h30]), 128'd0);
      chk(ld_cnt == 1 && ld_dst_cap == 5'd6, "R8 result of original load", 128'(ld_dst_cap), 128'd6);

      // R9: reset mid-flight returns to quiet state
      lat = 5;
      req_valid = 1; req_store = 1; req_dst = 5'd3; req_base = 32'h40; req_offset = '0;
      @(negedge clk);
      req_valid = 0;
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      chk(!mem_req && !busy && !ld_we, "R9 reset during access", 128'({mem_req, busy, ld_we}), 128'd0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule